// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two W-bit words one bit per clock, through a single combinational full adder and a carry flip-flop. The accumulator register holds the first operand and the addend register holds the second. A `start` pulse begins an addition run. On each of the next W clocks, the low bits of both registers and the stored carry go into the full adder. The sum bit enters the top of the accumulator as it shifts right, and the addend shifts right with zero fill. When the run ends, the accumulator holds the W-bit sum and `carry_out` holds the carry out of the top bit.

The run is stopped by an internal shift enable (`busy`), driven by a bit counter, so the clock is never gated. `done` pulses for one cycle when the run ends. Longer sums are built by loading a new addend and starting another run. The accumulator keeps the running total from one run to the next.

Top module: `serial_accum_adder`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc_out` is 0, `carry_out` is 0, and `busy` and `done` are 0.
- R2: While idle, `load_a` copies `a_in` into the accumulator, which shows on `acc_out` one cycle later.
- R3: A `start` seen while idle raises `busy` on the next cycle. `busy` then stays high for exactly W cycles. `done` is high only in the one cycle in which `busy` has just fallen.
- R4: Each run begins with the carry cleared. When `done` is high, `acc_out` equals (A + B) mod 2^W and `carry_out` equals bit W of A + B, where A and B are the register values at the start of the run.
- R5: Running again after loading a new addend adds that addend to the running total held in the accumulator.
- R6: While idle, `load_b` clears the carry flip-flop in addition to loading the addend.
- R7: While idle, `carry_clr` clears the carry flip-flop and leaves `acc_out` unchanged.
- R8: While `busy` is high, `load_a`, `load_b`, `carry_clr` and `start` have no effect on the result of the run in progress.
- R9: After a run the addend register holds zero. A second run with no new `load_b` leaves `acc_out` unchanged and ends with `carry_out` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| carry_clr | input | 1 | Clear the carry flip-flop (idle only) |
| load_a | input | 1 | Parallel load of the accumulator (idle only) |
| a_in | input | W | Accumulator load value |
| load_b | input | 1 | Parallel load of the addend, also clears carry (idle only) |
| b_in | input | W | Addend load value |
| start | input | 1 | Begin a W-cycle addition run (idle only) |
| acc_out | output | W | Parallel read of the accumulator |
| carry_out | output | 1 | Carry flip-flop value |
| busy | output | 1 | Internal shift enable, high during a run |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The main function is tried with a table of operand pairs: zeros, all-ones plus one, complementary patterns, two top-bit-only words, all-ones plus all-ones, and small values with no carry. Between them, these pairs separate a wrong carry path, a carry not cleared at the start of a run, and a sum bit entering at the wrong end. Chained runs with a new addend separate true accumulation from a plain one-shot adder. A run with no reload shows whether the addend register empties as it shifts. Pulses on the control inputs during a run that would carry out show whether those inputs are ignored while busy.

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         carry_clr,
  input  logic         load_a,
  input  logic [W-1:0] a_in,
  input  logic         load_b,
  input  logic [W-1:0] b_in,
  input  logic         start,
  output logic [W-1:0] acc_out,
  output logic         carry_out,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q, add_q;
  logic [CW-1:0] bit_cnt;
  logic          cy_q, run_q, done_q;
  logic          fa_s, fa_c, last_bit;

  assign fa_s     = acc_q[0] ^ add_q[0] ^ cy_q;
  assign fa_c     = (acc_q[0] & add_q[0]) | (cy_q & (acc_q[0] ^ add_q[0]));
  assign last_bit = (bit_cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      add_q   <= '0;
      cy_q    <= 1'b0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      bit_cnt <= '0;
    end else if (run_q) begin
      acc_q   <= {fa_s, acc_q[W-1:1]};
      add_q   <= {1'b0, add_q[W-1:1]};
      cy_q    <= fa_c;
      bit_cnt <= bit_cnt + 1'b1;
      run_q   <= !last_bit;
      done_q  <= last_bit;
    end else begin
      done_q <= 1'b0;
      if (load_a) acc_q <= a_in;
      if (load_b) add_q <= b_in;
      if (load_b || carry_clr || start) cy_q <= 1'b0;
      if (start) begin
        run_q   <= 1'b1;
        bit_cnt <= '0;
      end
    end
  end

  assign acc_out   = acc_q;
  assign carry_out = cy_q;
  assign busy      = run_q;
  assign done      = done_q;
endmodule

// File: rtl/serial_accum_adder_chk.sv
module serial_accum_adder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         carry_clr,
  input logic         load_a,
  input logic [W-1:0] a_in,
  input logic         load_b,
  input logic         start,
  input logic [W-1:0] acc_out,
  input logic         carry_out,
  input logic         busy,
  input logic         done
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (!busy) run_len <= '0;
    else run_len <= run_len + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (!busy && !done && !carry_out)); // R1
  AST_LOAD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_a) |=> (acc_out == $past(a_in))); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R3
  AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CW'(W) && done)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R3
  AST_START_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> !carry_out); // R4
  AST_LOADB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_b) |=> !carry_out); // R6
  AST_CLR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && carry_clr && !load_a) |=> (!carry_out && $stable(acc_out))); // R7
endmodule

bind serial_accum_adder serial_accum_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .carry_clr(carry_clr), .load_a(load_a),
  .a_in(a_in), .load_b(load_b), .start(start), .acc_out(acc_out),
  .carry_out(carry_out), .busy(busy), .done(done)
);

// File: tb/serial_accum_adder_bench.sv
module serial_accum_adder_bench;
  localparam int W = 8;
  localparam int NV = 7;
  localparam logic [W*3:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 8'h00},
    {8'hFF, 8'h01, 1'b1, 8'h00},
    {8'h5A, 8'hA5, 1'b0, 8'hFF},
    {8'h80, 8'h80, 1'b1, 8'h00},
    {8'h3C, 8'h0F, 1'b0, 8'h4B},
    {8'hFF, 8'hFF, 1'b1, 8'hFE},
    {8'h12, 8'h34, 1'b0, 8'h46}
  };

  logic clk = 0, rst_n = 0;
  logic carry_clr = 0, load_a = 0, load_b = 0, start = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] acc_out;
  logic carry_out, busy, done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  serial_accum_adder #(.W(W)) u_serial_accum_adder (
    .clk(clk), .rst_n(rst_n), .carry_clr(carry_clr), .load_a(load_a),
    .a_in(a_in), .load_b(load_b), .b_in(b_in), .start(start),
    .acc_out(acc_out), .carry_out(carry_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_both(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load_a = 1; a_in = a; load_b = 1; b_in = b;
    @(negedge clk);
    load_a = 0; load_b = 0;
  endtask

  task automatic run_add(input bit disturb, input string req,
                         input logic [W-1:0] exp_sum, input logic exp_c);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R3 busy", busy, 1);
    for (int i = 1; i < W; i++) begin
      if (disturb && i == 3) begin
        load_a = 1; a_in = 8'hC3; load_b = 1; b_in = 8'h77; carry_clr = 1; start = 1;
      end
      @(negedge clk);
      load_a = 0; load_b = 0; carry_clr = 0; start = 0;
    end
    chk(busy === 1'b1 && done === 1'b0, "R3 length", {busy, done}, 2);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b1, "R3 done", {busy, done}, 1);
    chk(acc_out === exp_sum, {req, " sum"}, acc_out, exp_sum);
    chk(carry_out === exp_c, {req, " carry"}, carry_out, exp_c);
    @(negedge clk);
    chk(done === 1'b0, "R3 pulse", done, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk(acc_out === '0 && carry_out === 0 && busy === 0 && done === 0, "R1 in reset",
        {acc_out, carry_out, busy, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(acc_out === '0 && carry_out === 0 && busy === 0 && done === 0, "R1 after reset",
        {acc_out, carry_out, busy, done}, 0);

    for (int v = 0; v < NV; v++) begin
      load_both(VEC[v][24:17], VEC[v][16:9]);
      chk(acc_out === VEC[v][24:17], "R2 load", acc_out, VEC[v][24:17]);
      run_add(0, "R4", VEC[v][7:0], VEC[v][8]);
    end

    // R6: load_b clears a set carry
    chk(carry_out === 1'b0, "R6 pre", carry_out, 0);
    load_both(8'hFF, 8'hFF);
    run_add(0, "R4", 8'hFE, 1'b1);
    @(negedge clk); load_b = 1; b_in = 8'h00;
    @(negedge clk); load_b = 0;
    chk(carry_out === 1'b0, "R6 load_b clears carry", carry_out, 0);

    // R7: carry_clr clears carry, acc unchanged
    load_both(8'hF0, 8'h20);
    run_add(0, "R4", 8'h10, 1'b1);
    @(negedge clk); carry_clr = 1;
    @(negedge clk); carry_clr = 0;
    chk(carry_out === 1'b0, "R7 carry cleared", carry_out, 0);
    chk(acc_out === 8'h10, "R7 acc kept", acc_out, 8'h10);

    // R8: controls pulsed mid-run are ignored
    load_both(8'hFF, 8'h01);
    run_add(1, "R8", 8'h00, 1'b1);

    // R5: accumulation across runs
    load_both(8'h10, 8'h20);
    run_add(0, "R5 first", 8'h30, 1'b0);
    @(negedge clk); load_b = 1; b_in = 8'h05;
    @(negedge clk); load_b = 0;
    run_add(0, "R5 second", 8'h35, 1'b0);
    @(negedge clk); load_b = 1; b_in = 8'hD0;
    @(negedge clk); load_b = 0;
    run_add(0, "R5 wrap", 8'h05, 1'b1);

    // R9: addend emptied, rerun leaves total unchanged
    run_add(0, "R9", 8'h05, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule